// File: doc/BRIEF.md
# Banked Memory Window Decoder

This block sits between an 8-bit processor with a 16-bit address bus and its memories. It opens a 16K window in the processor's map at 0x8000 to 0xBFFF and points that window at any one of 32 pages of a 512K data memory. A small bank register chooses the page. All other addresses keep a fixed upper address, so code fetched from the lower RAM or from program memory never moves when software changes the bank.

The block also generates the processor's phase-2 clock from a master oscillator. The clock runs either at half the oscillator rate (fast) or at a quarter of it (slow). Slow mode is selected out of reset so that a boot-time copy from slow memories can run safely. The bank and speed settings share one I/O page, 0xDExx. A write there updates both settings. A read there returns both settings through the data bus drive enable. The bank value can therefore be read back and never floats on the bus.

Top module: `bankwin_decoder`

## Requirements
- R1: When the address high byte `a_hi` is 0x80 to 0xBF, the extended address `xa` (upper address lines A18..A14) equals the current 5-bit bank value.
- R2: For every `a_hi` outside 0x80 to 0xBF, `xa` is 0, whatever the bank value.
- R3: The chip selects are active low and at most one is active at a time. `ram_cs_n` covers 0x00 to 0x7F, `data_cs_n` covers 0x80 to 0xBF, and `prog_cs_n` covers 0xC0 to 0xFF except 0xDE. The page 0xDE activates none of them.
- R4: `mem_oe_n` is low only while `phi2` is high, `rw` is high (read) and a chip select is active.
- R5: A write (`rw` low) to page 0xDE, held through a falling edge of `phi2`, loads the bank from `d_in[4:0]` and the slow flag from `d_in[7]`. `d_in[6:5]` are ignored. Writes to any other page, and reads of 0xDE, leave both settings unchanged.
- R6: While `phi2` is high, `rw` is high and `a_hi` is 0xDE, `d_oe` is 1 and `d_out` is {slow, 2'b00, bank}. At all other times `d_oe` is 0.
- R7: While `rst_n` is low, `phi2` is 0, `d_oe` is 0 and `mem_oe_n` is 1. Reset leaves the bank at 0 and the slow flag at 1, so a read returns 0x80.
- R8: In slow mode each half-phase of `phi2` lasts 2 `clk` cycles, and in fast mode it lasts 1. A speed change takes effect only at a `phi2` edge, so no half-phase is cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_hi | input | 8 | Processor address bits A15..A8 |
| rw | input | 1 | 1 = read, 0 = write |
| d_in | input | 8 | Data bus as seen by the block |
| phi2 | output | 1 | Generated phase-2 clock |
| xa | output | 5 | Extended address A18..A14 |
| ram_cs_n | output | 1 | Lower RAM select, active low |
| data_cs_n | output | 1 | Banked data memory select, active low |
| prog_cs_n | output | 1 | Program memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| d_out | output | 8 | Settings value for the data bus |
| d_oe | output | 1 | Enable for the data bus tri-state driver |

## Verification
A wrong bank value shows up on `xa` during the first window access after the faulty write, and also on `d_out` during the next read of page 0xDE. The bench therefore checks each write by reading it back and by walking through the window. A divider or speed flag in the wrong state shows up within one or two `phi2` half-phases as the wrong toggle count over a fixed span of `clk` cycles. A decode fault shows up at once as a wrong chip select or as an output enable outside the read phase.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;
  localparam int unsigned ADDR_HI_W = 8;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned BANK_W    = 5;
  localparam int unsigned SLOW_BIT  = 7;
  localparam int unsigned TAG_W     = 2;
  localparam logic [TAG_W-1:0]     WIN_TAG  = 2'b10;
  localparam logic [TAG_W-1:0]     PROG_TAG = 2'b11;
  localparam logic [ADDR_HI_W-1:0] IO_PAGE  = 8'hDE;
  localparam logic [BANK_W-1:0]    FIXED_XA = '0;
endpackage

// File: rtl/bankwin_rst_sync.sv
module bankwin_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bankwin_clkgen.sv
module bankwin_clkgen #(
  parameter logic RESET_SLOW = 1'b1
) (
  input  logic clk,
  input  logic srst_n,
  input  logic slow_req,
  output logic phi2,
  output logic phi2_fall
);
  logic phi2_q, phi2_d;
  logic held_q, held_d;
  logic act_slow_q, act_slow_d;
  logic edge_now;

  always_comb begin
    edge_now   = !act_slow_q || held_q;
    phi2_d     = edge_now ? !phi2_q : phi2_q;
    held_d     = !edge_now;
    act_slow_d = edge_now ? slow_req : act_slow_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phi2_q     <= 1'b0;
      held_q     <= 1'b0;
      act_slow_q <= RESET_SLOW;
    end else begin
      phi2_q     <= phi2_d;
      held_q     <= held_d;
      act_slow_q <= act_slow_d;
    end
  end

  assign phi2      = phi2_q;
  assign phi2_fall = phi2_q && edge_now;

  // R8: a slow half-phase spans two clk cycles
  p_slow_half_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (act_slow_q && !$stable(phi2_q)) |=> $stable(phi2_q));
  // R8: the active speed changes only together with a phase edge
  p_switch_edge_r8: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(act_slow_q) |-> !$stable(phi2_q));
endmodule

// File: rtl/bankwin_regs.sv
module bankwin_regs #(
  parameter int unsigned BANK_W     = 5,
  parameter logic        RESET_SLOW = 1'b1
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] bank_in,
  input  logic              slow_in,
  output logic [BANK_W-1:0] bank,
  output logic              slow
);
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              slow_q, slow_d;

  always_comb begin
    bank_d = bank_q;
    slow_d = slow_q;
    if (wr_en) begin
      bank_d = bank_in;
      slow_d = slow_in;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      bank_q <= '0;
      slow_q <= RESET_SLOW;
    end else begin
      bank_q <= bank_d;
      slow_q <= slow_d;
    end
  end

  assign bank = bank_q;
  assign slow = slow_q;

  // R5: no write strobe, no change of the settings
  p_bank_hold_r5: assert property (@(posedge clk) disable iff (!srst_n)
    !wr_en |=> ($stable(bank_q) && $stable(slow_q)));
  // R5: a strobe captures the presented data
  p_bank_load_r5: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en |=> (bank_q == $past(bank_in)));
endmodule

// File: rtl/bankwin_map.sv
module bankwin_map
  import bankwin_pkg::*;
#(
  parameter int unsigned AW = ADDR_HI_W,
  parameter int unsigned BW = BANK_W
) (
  input  logic          srst_n,
  input  logic          clk,
  input  logic [AW-1:0] a_hi,
  input  logic          rw,
  input  logic          phi2,
  input  logic [BW-1:0] bank,
  output logic [BW-1:0] xa,
  output logic          ram_cs_n,
  output logic          data_cs_n,
  output logic          prog_cs_n,
  output logic          mem_oe_n,
  output logic          io_hit
);
  localparam int unsigned NSEL = 3;
  logic [TAG_W-1:0] tag;
  logic [NSEL-1:0]  sel;
  logic             in_win;

  always_comb begin
    tag    = a_hi[AW-1 -: TAG_W];
    io_hit = (a_hi == IO_PAGE);
    in_win = (tag == WIN_TAG);
    sel[0] = !tag[TAG_W-1];
    sel[1] = in_win;
    sel[2] = (tag == PROG_TAG) && !io_hit;
  end

  generate
    for (genvar i = 0; i < BW; i++) begin : g_xa
      assign xa[i] = in_win ? bank[i] : FIXED_XA[i];
    end
  endgenerate

  assign ram_cs_n  = !sel[0];
  assign data_cs_n = !sel[1];
  assign prog_cs_n = !sel[2];
  assign mem_oe_n  = !(phi2 && rw && (|sel));

  // R3: never two memories selected at once
  p_cs_excl_r3: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({ram_cs_n, data_cs_n, prog_cs_n} ^ 3'b111));
  // R3: the I/O page selects no memory
  p_io_nosel_r3: assert property (@(posedge clk) disable iff (!srst_n)
    io_hit |-> (ram_cs_n && data_cs_n && prog_cs_n));
  // R4: memory output enable only in a read during phase-2 high
  p_oe_gate_r4: assert property (@(posedge clk) disable iff (!srst_n)
    !mem_oe_n |-> (phi2 && rw));
endmodule

// File: rtl/bankwin_decoder.sv
module bankwin_decoder
  import bankwin_pkg::*;
#(
  parameter int unsigned AW         = ADDR_HI_W,
  parameter int unsigned DW         = DATA_W,
  parameter int unsigned BW         = BANK_W,
  parameter int unsigned SB         = SLOW_BIT,
  parameter logic        RESET_SLOW = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_hi,
  input  logic          rw,
  input  logic [DW-1:0] d_in,
  output logic          phi2,
  output logic [BW-1:0] xa,
  output logic          ram_cs_n,
  output logic          data_cs_n,
  output logic          prog_cs_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] d_out,
  output logic          d_oe
);
  logic          srst_n;
  logic          phi2_fall;
  logic          io_hit;
  logic          wr_en;
  logic [BW-1:0] bank;
  logic          slow;
  logic          d_unused;

  bankwin_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  bankwin_clkgen #(.RESET_SLOW(RESET_SLOW)) u_clk (
    .clk(clk), .srst_n(srst_n), .slow_req(slow),
    .phi2(phi2), .phi2_fall(phi2_fall));

  assign wr_en    = phi2_fall && !rw && io_hit;
  assign d_unused = ^d_in;

  bankwin_regs #(.BANK_W(BW), .RESET_SLOW(RESET_SLOW)) u_regs (
    .clk(clk), .srst_n(srst_n), .wr_en(wr_en),
    .bank_in(d_in[BW-1:0]), .slow_in(d_in[SB]),
    .bank(bank), .slow(slow));

  bankwin_map #(.AW(AW), .BW(BW)) u_map (
    .srst_n(srst_n), .clk(clk), .a_hi(a_hi), .rw(rw), .phi2(phi2),
    .bank(bank), .xa(xa), .ram_cs_n(ram_cs_n), .data_cs_n(data_cs_n),
    .prog_cs_n(prog_cs_n), .mem_oe_n(mem_oe_n), .io_hit(io_hit));

  always_comb begin
    d_out         = '0;
    d_out[BW-1:0] = bank;
    d_out[SB]     = slow;
  end

  assign d_oe = io_hit && rw && phi2;

  // R6: the bus is driven only inside phase-2 high of a read
  p_drive_phase_r6: assert property (@(posedge clk) disable iff (!srst_n)
    d_oe |-> (phi2 && rw));
  // R1: inside the window the upper lines follow the read-back bank
  p_win_xa_r1: assert property (@(posedge clk) disable iff (!srst_n)
    !data_cs_n |-> (xa == d_out[BW-1:0]));
  // R2: outside the window the upper lines stay fixed
  p_fixed_xa_r2: assert property (@(posedge clk) disable iff (!srst_n)
    data_cs_n |-> (xa == FIXED_XA));
endmodule

// File: tb/bankwin_decoder_test.sv
module bankwin_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] a_hi;
  logic       rw;
  logic [7:0] d_in;
  logic       phi2;
  logic [4:0] xa;
  logic       ram_cs_n, data_cs_n, prog_cs_n, mem_oe_n;
  logic [7:0] d_out;
  logic       d_oe;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bankwin_decoder uut (
    .clk(clk), .rst_n(rst_n), .a_hi(a_hi), .rw(rw), .d_in(d_in),
    .phi2(phi2), .xa(xa), .ram_cs_n(ram_cs_n), .data_cs_n(data_cs_n),
    .prog_cs_n(prog_cs_n), .mem_oe_n(mem_oe_n), .d_out(d_out), .d_oe(d_oe));

  // {a_hi, rw, active selects ram/data/prog, d_oe, xa} with bank = 0x13
  localparam logic [17:0] VEC [12] = '{
    {8'h00, 1'b1, 3'b100, 1'b0, 5'h00},
    {8'h7F, 1'b0, 3'b100, 1'b0, 5'h00},
    {8'h80, 1'b1, 3'b010, 1'b0, 5'h13},
    {8'hA5, 1'b0, 3'b010, 1'b0, 5'h13},
    {8'hBF, 1'b1, 3'b010, 1'b0, 5'h13},
    {8'hC0, 1'b1, 3'b001, 1'b0, 5'h00},
    {8'hDD, 1'b1, 3'b001, 1'b0, 5'h00},
    {8'hDE, 1'b1, 3'b000, 1'b1, 5'h00},
    {8'hDF, 1'b0, 3'b001, 1'b0, 5'h00},
    {8'hE0, 1'b1, 3'b001, 1'b0, 5'h00},
    {8'hFF, 1'b1, 3'b001, 1'b0, 5'h00},
    {8'h40, 1'b1, 3'b100, 1'b0, 5'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    a_hi = 8'h00; rw = 1'b1; d_in = 8'h00;
  endtask

  task automatic write_cfg(input logic [7:0] val);
    @(negedge clk);
    a_hi = 8'hDE; rw = 1'b0; d_in = val;
    @(negedge phi2);
    @(negedge clk);
    idle();
  endtask

  task automatic read_cfg(input string tag, input logic [7:0] exp);
    @(negedge clk);
    a_hi = 8'hDE; rw = 1'b1;
    @(posedge phi2);
    @(negedge clk);
    chk(tag, {23'd0, d_oe, d_out}, {23'd0, 1'b1, exp});
    idle();
  endtask

  task automatic count_edges(input string tag, input int exp);
    logic prev;
    int   n;
    repeat (4) @(negedge clk);
    prev = phi2;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (phi2 !== prev) n++;
      prev = phi2;
    end
    chk(tag, n, exp);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R7: outputs quiet while reset is held
    chk("R7 reset outputs", {phi2, d_oe, mem_oe_n}, 3'b001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    read_cfg("R7 reset value (R6 readback)", 8'h80);
    count_edges("R8 slow half-phase", 4);

    write_cfg(8'h13);
    read_cfg("R5 load bank and fast", 8'h13);
    count_edges("R8 fast half-phase", 8);

    // R1 R2 R3 R4 R6 vector walk
    foreach (VEC[k]) begin
      logic [17:0] v;
      logic        exp_oe_n;
      v = VEC[k];
      @(negedge clk);
      a_hi = v[17:10]; rw = v[9];
      @(posedge phi2);
      @(negedge clk);
      exp_oe_n = !(v[9] && (|v[8:6]));
      chk($sformatf("R1/R2/R3/R4/R6 vector %0d", k),
          {ram_cs_n, data_cs_n, prog_cs_n, mem_oe_n, d_oe, xa},
          {~v[8:6], exp_oe_n, v[5], v[4:0]});
    end
    idle();

    read_cfg("R5 other-page writes and reads ignored", 8'h13);

    // R4 and R6: no enables while phi2 is low
    @(negedge clk);
    a_hi = 8'hDE; rw = 1'b1;
    @(negedge phi2);
    @(negedge clk);
    chk("R6 no drive in phi2 low", {d_oe, phi2}, 2'b00);
    a_hi = 8'h90;
    @(negedge clk);
    if (phi2 == 1'b0) chk("R4 no oe in phi2 low", mem_oe_n, 1'b1);
    idle();

    write_cfg(8'hFF);
    read_cfg("R5 bits 6:5 ignored", 8'h9F);
    count_edges("R8 back to slow", 4);

    @(negedge clk);
    a_hi = 8'h80;
    #1 chk("R1 window follows bank", xa, 5'h1F);
    a_hi = 8'hC0;
    #1 chk("R2 program fetch fixed", xa, 5'h00);
    a_hi = 8'h3F;
    #1 chk("R2 low ram fixed", xa, 5'h00);
    idle();

    write_cfg(8'h05);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_cfg("R7 reset clears bank", 8'h80);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule